// File: doc/BRIEF.md
# CAN Transmit Dominant Time-out Guard

This block sits in the path from a CAN controller's transmit output to the transceiver driver. It guards against a failure in hardware or software that leaves the transmit line stuck in the dominant (low) state. Such a fault would hold the whole bus dominant and stop all traffic on the network.

The raw transmit line first passes through a synchronizer. The block then counts system clocks for as long as the synchronized line stays low. If the low time passes the limit on the `limit` port, the block disables the transmitter and holds the driver output recessive (high). It also sets a fault flag that stays set until software clears it. The transmitter is enabled again as soon as the synchronized line is seen high.

The limit must be longer than the longest legal dominant run at the lowest bit rate the system supports, which is 40 kbit/s. At a 50 MHz clock one bit lasts 1250 cycles. A stuffed dominant run plus margin is about 11 bit times, or 13750 cycles, so a limit of 16000 is suitable. This limit is what sets the lowest usable bit rate.

Top module: `can_txd_guard`

## Requirements
- R1: After reset, `txEn` is 1, `txdOut` is 1 (recessive) and `faultSticky` is 0.
- R2: While the transmitter is enabled, `txdOut` equals `txdRaw` delayed by exactly two clock cycles. This delay comes from the two-stage synchronizer.
- R3: The dominant counter advances once per clock while the synchronized line is low. The transmitter is disabled on the edge that takes the (limit+1)th consecutive low synchronized sample. Counted from the first edge that sees `txdRaw` low, `txEn` is 0 after exactly limit+3 clock edges.
- R4: Any high synchronized sample clears the counter to zero. Low runs of `limit` samples or fewer, separated by one high sample, therefore never disable the transmitter.
- R5: While `txEn` is 0, `txdOut` is held at 1 whatever `txdRaw` does.
- R6: Once disabled, the transmitter is enabled again 3 clock edges after `txdRaw` returns high. This is the first clock on which the synchronized line is seen high. The counter then starts again from zero, and `faultSticky` stays at 1.
- R7: `faultSticky` is set to 1 on the edge where the time-out fires. It stays at 1 until a clock edge on which `faultClr` is 1 and no new time-out fires. A time-out that fires on the same edge takes priority over the clear.
- R8: With `limit` equal to 0, the first low synchronized sample disables the transmitter. `txEn` is 0 three edges after `txdRaw` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txdRaw | input | 1 | Transmit line from the CAN controller (0 = dominant) |
| faultClr | input | 1 | Clears the sticky fault flag |
| limit | input | CNT_W | Time-out limit in clock cycles |
| txdOut | output | 1 | Gated transmit line to the transceiver driver |
| txEn | output | 1 | Transmitter enable (1 = enabled) |
| faultSticky | output | 1 | Sticky time-out fault flag |

## Verification
The assertions check on every cycle the rules that hold at each clock edge:

- a firing time-out disables the transmitter and sets the fault on the next edge;
- a high synchronized sample empties the counter;
- a blocked guard re-enables on the first high sample;
- the fault survives until a clear;
- the output stays high while the transmitter is blocked.

Only the bench scenarios can show the exact limit+3 latency from a raw falling edge to the disable. The same holds for glitch sequences that keep low runs just under the limit, the zero-limit case, and the full-size 40 kbit/s limit. A cycle model in the bench covers long random streams that mix all of these.

// File: rtl/can_txd_guard_pkg.sv
package can_txd_guard_pkg;

  typedef enum logic {
    GUARD_ACTIVE  = 1'b0,
    GUARD_BLOCKED = 1'b1
  } guardState_t;

  typedef struct packed {
    logic clrCnt;
    logic countEn;
    logic forceRec;
  } guardStrobe_t;

endpackage

// File: rtl/can_txd_guard_dp.sv
module can_txd_guard_dp
  import can_txd_guard_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txdRaw,
  input  logic [CNT_W-1:0] limit,
  input  guardStrobe_t     strobes,
  output logic             txdSync,
  output logic             expire,
  output logic             txdOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CNT_W-1:0]       domCnt;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b1;
          else       syncReg[g] <= txdRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b1;
          else       syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  assign txdSync = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domCnt <= '0;
    end else if (strobes.clrCnt || txdSync) begin
      domCnt <= '0;
    end else if (strobes.countEn && (domCnt != CNT_MAX)) begin
      domCnt <= domCnt + 1'b1;
    end
  end

  assign expire = !txdSync && (domCnt >= limit);
  assign txdOut = strobes.forceRec ? 1'b1 : txdSync;

  // R4: a high synchronized sample leaves the counter empty
  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    txdSync |=> (domCnt == '0));

  // R5: the forced output is recessive
  assert_force_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceRec |-> txdOut);

endmodule

// File: rtl/can_txd_guard_ctrl.sv
module can_txd_guard_ctrl
  import can_txd_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txdSync,
  input  logic         expire,
  input  logic         faultClr,
  output guardStrobe_t strobes,
  output logic         txEn,
  output logic         faultSticky
);

  guardState_t state, stateNext;
  logic        trip;

  assign trip = (state == GUARD_ACTIVE) && expire;

  always_comb begin
    stateNext = state;
    case (state)
      GUARD_ACTIVE:  if (trip)    stateNext = GUARD_BLOCKED;
      GUARD_BLOCKED: if (txdSync) stateNext = GUARD_ACTIVE;
      default:                    stateNext = GUARD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GUARD_ACTIVE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultSticky <= 1'b0;
    else if (trip)     faultSticky <= 1'b1;
    else if (faultClr) faultSticky <= 1'b0;
  end

  always_comb begin
    strobes.clrCnt   = trip || ((state == GUARD_BLOCKED) && txdSync);
    strobes.countEn  = (state == GUARD_ACTIVE);
    strobes.forceRec = (state == GUARD_BLOCKED);
  end

  assign txEn = (state == GUARD_ACTIVE);

  // R3: a firing time-out blocks the transmitter and flags the fault
  assert_trip_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && expire) |=> (!txEn && faultSticky));

  // R6: a blocked guard re-enables on the first high sample
  assert_reenable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn && txdSync) |=> txEn);

  // R7: the fault holds until a clear arrives
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (faultSticky && !faultClr) |=> faultSticky);

  // R7: a disable always comes with the fault flag
  assert_fall_sets_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEn) |-> faultSticky);

endmodule

// File: rtl/can_txd_guard.sv
module can_txd_guard
  import can_txd_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txdRaw,
  input  logic             faultClr,
  input  logic [CNT_W-1:0] limit,
  output logic             txdOut,
  output logic             txEn,
  output logic             faultSticky
);

  localparam int SYNC_STAGES = 2;

  guardStrobe_t strobes;
  logic         txdSync;
  logic         expire;

  can_txd_guard_dp #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .txdRaw (txdRaw),
    .limit  (limit),
    .strobes(strobes),
    .txdSync(txdSync),
    .expire (expire),
    .txdOut (txdOut)
  );

  can_txd_guard_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .txdSync    (txdSync),
    .expire     (expire),
    .faultClr   (faultClr),
    .strobes    (strobes),
    .txEn       (txEn),
    .faultSticky(faultSticky)
  );

endmodule

// File: tb/tb_can_txd_guard.sv
module tb_can_txd_guard;

  localparam int CNT_W       = 16;
  localparam int BIG_LIMIT   = 16000;
  localparam int MAX_CYCLES  = 200000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             txdRaw = 1'b1;
  logic             faultClr = 1'b0;
  logic [CNT_W-1:0] limit = 16'd20;
  logic             txdOut, txEn, faultSticky;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  can_txd_guard #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .txdRaw(txdRaw), .faultClr(faultClr),
    .limit(limit), .txdOut(txdOut), .txEn(txEn), .faultSticky(faultSticky)
  );

  always #10 clk = ~clk;

  // cycle model derived from the requirements
  bit         mS1 = 1, mS2 = 1, mBlk = 0, mFault = 0;
  int         mCnt = 0;

  function automatic bit modelTrip(bit blk, bit s2, int cnt, int lim);
    return !blk && !s2 && (cnt >= lim);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mBlk = 0; mFault = 0; mCnt = 0;
    end else begin
      bit trip, nBlk, nFault;
      int nCnt;
      trip   = modelTrip(mBlk, mS2, mCnt, int'(limit));
      nBlk   = mBlk ? !mS2 : trip;
      nCnt   = (mS2 || trip) ? 0 : (!mBlk && mCnt != 65535) ? mCnt + 1 : mCnt;
      nFault = trip ? 1'b1 : (faultClr ? 1'b0 : mFault);
      mS2 = mS1; mS1 = txdRaw; mBlk = nBlk; mCnt = nCnt; mFault = nFault;
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic checkInt(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check(curReq, txEn, !mBlk, "txEn vs model");
    check(curReq, txdOut, mBlk ? 1'b1 : mS2, "txdOut vs model");
    check(curReq, faultSticky, mFault, "fault vs model");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, MAX_CYCLES);
      finishRun();
    end
  end

  function automatic int latencyFor(int lim);
    return lim + 3;
  endfunction

  task automatic waitDisable(string req, int lim);
    int n = 0;
    for (int i = 0; i < lim + 20; i++) begin
      cyc();
      n++;
      if (!txEn) break;
    end
    checkInt(req, n, latencyFor(lim), "edges until disable");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", txEn, 1'b1, "txEn at reset");
    check("R1", txdOut, 1'b1, "txdOut at reset");
    check("R1", faultSticky, 1'b0, "fault at reset");
    rstN = 1'b1;
    cyc();

    // R2: pass-through with two-cycle delay
    curReq = "R2";
    limit = 16'd1000;
    for (int i = 0; i < 300; i++) begin
      txdRaw = ($urandom_range(0, 3) != 0);
      cyc();
    end
    txdRaw = 1'b1; cyc(); txdRaw = 1'b0; cyc();
    check("R2", txdOut, 1'b1, "one edge after fall");
    cyc();
    check("R2", txdOut, 1'b0, "two edges after fall");
    txdRaw = 1'b1; repeat (3) cyc();

    // R3: stuck-low trip latency
    curReq = "R3";
    limit = 16'd20;
    txdRaw = 1'b0;
    waitDisable("R3", 20);
    check("R3", faultSticky, 1'b1, "fault after trip");

    // R5: output held recessive while blocked
    curReq = "R5";
    for (int i = 0; i < 10; i++) begin
      cyc();
      check("R5", txdOut, 1'b1, "txdOut while blocked");
    end

    // R6: re-enable after the line returns high
    curReq = "R6";
    txdRaw = 1'b1;
    cyc(); cyc();
    check("R6", txEn, 1'b0, "still blocked after 2 edges");
    cyc();
    check("R6", txEn, 1'b1, "enabled after 3 edges");
    check("R6", faultSticky, 1'b1, "fault stays set");

    // R7: sticky until cleared
    curReq = "R7";
    repeat (5) cyc();
    check("R7", faultSticky, 1'b1, "fault held");
    faultClr = 1'b1; cyc(); faultClr = 1'b0;
    check("R7", faultSticky, 1'b0, "fault cleared");
    // clear held through a trip: set wins on the trip edge
    limit = 16'd5; faultClr = 1'b1; txdRaw = 1'b0;
    waitDisable("R7", 5);
    check("R7", faultSticky, 1'b1, "set wins over clear");
    cyc();
    check("R7", faultSticky, 1'b0, "clear after trip edge");
    faultClr = 1'b0; txdRaw = 1'b1; repeat (4) cyc();

    // R4: runs at the limit split by a single high sample
    curReq = "R4";
    limit = 16'd20;
    for (int r = 0; r < 4; r++) begin
      txdRaw = 1'b0; repeat (20) cyc();
      txdRaw = 1'b1; cyc();
    end
    repeat (3) cyc();
    check("R4", txEn, 1'b1, "no trip for runs of limit");
    check("R4", faultSticky, 1'b0, "no fault for runs of limit");

    // R8: zero limit
    curReq = "R8";
    limit = 16'd0; txdRaw = 1'b0;
    waitDisable("R8", 0);
    txdRaw = 1'b1; repeat (4) cyc();
    faultClr = 1'b1; cyc(); faultClr = 1'b0;

    // R3: randomized mix of limits and pulse lengths
    curReq = "R3";
    for (int k = 0; k < 150; k++) begin
      int len;
      limit = 16'($urandom_range(0, 30));
      len = $urandom_range(1, 40);
      txdRaw = 1'b0;
      repeat (len) cyc();
      txdRaw = 1'b1;
      faultClr = ($urandom_range(0, 3) == 0);
      repeat ($urandom_range(1, 4)) cyc();
      faultClr = 1'b0;
    end
    txdRaw = 1'b1; repeat (4) cyc();

    // R3: full-size limit for a 40 kbit/s floor at 50 MHz
    limit = 16'(BIG_LIMIT);
    txdRaw = 1'b0;
    waitDisable("R3", BIG_LIMIT);
    txdRaw = 1'b1; repeat (4) cyc();

    finishRun();
  end

endmodule